// File: doc/BRIEF.md
# Multichannel DMA Channel Control and Status Bank

This block is the global control and status register bank of a DMA controller with up to 64 channels. For every channel it holds six state bits: request enable, error-interrupt enable, interrupt pending, error pending, done and start. It also holds a two-bit arbitration control field and a single error syndrome word that records the first error reported by the channel engines. Software reaches the bank over a simple word-addressed write/read bus with byte enables. The channel engines reach it through per-channel set and acknowledge vectors.

Each per-channel vector is read and written as two 32-bit words, a high word and a low word. Software changes a single channel's bit without a read-modify-write. It writes that channel's number into one lane of one of the two command words. Interrupt-pending and error-pending words are write-one-to-clear. One combined interrupt output summarises the pending state. The channel count is a parameter. A build with 32 or fewer channels implements only the low words.

Top module: `dmacsr_top`

## Requirements
- R1: After reset every readable word reads zero, `irq` is low, and `chan_req_en`, `chan_start` and both arbitration outputs are zero.
- R2: Channel c maps to bit c of the low word for c < 32 and to bit c-32 of the high word otherwise. Request-enable words (word 2 high, word 3 low) and error-interrupt-enable words (4 high, 5 low) are read/write, one byte lane per byte enable. The `chan_req_en` output reflects the request-enable bits.
- R3: Command word A (word 6, byte offset 0x18) takes a channel number per byte lane. Lane 0 (bits 7:0) sets request enable, lane 1 clears request enable, lane 2 sets error-interrupt enable, lane 3 clears error-interrupt enable. Several lanes may be used in one write.
- R4: Command word B (word 7, byte offset 0x1C) also takes a channel number per lane. Lane 0 clears interrupt pending, lane 1 clears error pending, lane 2 sets start, lane 3 clears done.
- R5: A command byte whose value is not below the channel count changes nothing.
- R6: Interrupt-pending words (8 high, 9 low) and error-pending words (10 high, 11 low) are write-one-to-clear. Writing all ones clears the whole word, and zero bits leave their channels unchanged. `eng_int_set` and `eng_err_set` set those bits.
- R7: When a set and a clear of the same bit fall in the same cycle, the bit ends cleared. This applies to engine set against command or write-one clear, to a set-lane and clear-lane pair in one write, and to a start command against `eng_start_ack`.
- R8: The syndrome word (word 1, read-only) captures a report while its valid bit is clear. Bit 31 is valid, bits 13:8 hold the channel, bit 15 is `eng_rpt_code[9]`, bit 14 is `eng_rpt_code[8]`, and bits 7:0 are `eng_rpt_code[7:0]`. All other bits are zero. While valid is set, later reports are ignored.
- R9: A clear-error command (word 7, lane 1) naming the syndrome's channel clears only the valid bit. A clear-error command naming any other channel leaves the syndrome unchanged.
- R10: `irq` is high exactly when some interrupt-pending bit is set, or some error-pending bit is set on a channel whose error-interrupt enable is set.
- R11: Control word 0 keeps bits 3 (round-robin group arbitration, `arb_rr_group`) and 2 (round-robin channel arbitration, `arb_rr_chan`), written under byte enable 0. All other bits read zero.
- R12: With a channel count of 32 or less, every high word reads zero and writes to it have no effect.
- R13: Done bits (words 12 high, 13 low) are set by `eng_done_set`. Start bits (words 14 high, 15 low) drive `chan_start` and are cleared by `eng_start_ack`. Both are read-only over the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables, bit n for bits 8n+7:8n |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| eng_int_set | input | NCH | Per-channel interrupt-pending set |
| eng_err_set | input | NCH | Per-channel error-pending set |
| eng_done_set | input | NCH | Per-channel done set |
| eng_start_ack | input | NCH | Per-channel start clear |
| eng_rpt_valid | input | 1 | Error report strobe |
| eng_rpt_chan | input | 6 | Failing channel of the report |
| eng_rpt_code | input | 10 | Report flags: priority errors in 9:8, transfer errors in 7:0 |
| chan_req_en | output | NCH | Request enable per channel |
| chan_start | output | NCH | Start bit per channel |
| arb_rr_group | output | 1 | Round-robin group arbitration select |
| arb_rr_chan | output | 1 | Round-robin channel arbitration select |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check that a clear always beats a set on the same bit and that a set without a clear lands. They also check that the syndrome holds its first capture until the matching clear-error command, and that the matching clear drops valid. Further assertions check that an out-of-range command byte leaves the request enables untouched and that the arbitration outputs follow a control write. The bench scenarios are what show the word split and the lane-to-command mapping. The scenarios also cover the write-one-to-clear masks, the interrupt combination with and without the error-interrupt enable, and the 16-channel build with its empty high words.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CSR_AW  = 4;
  localparam int unsigned LANES   = WORD_W / 8;
  localparam int unsigned NCMD    = 2 * LANES;
  localparam int unsigned CODE_W  = 10;
  localparam int unsigned RCH_W   = 6;

  // word addresses
  localparam logic [CSR_AW-1:0] A_CTRL     = 4'd0;
  localparam logic [CSR_AW-1:0] A_SYND     = 4'd1;
  localparam logic [CSR_AW-1:0] A_REQ_HI   = 4'd2;
  localparam logic [CSR_AW-1:0] A_REQ_LO   = 4'd3;
  localparam logic [CSR_AW-1:0] A_EIE_HI   = 4'd4;
  localparam logic [CSR_AW-1:0] A_EIE_LO   = 4'd5;
  localparam logic [CSR_AW-1:0] A_CMD_A    = 4'd6;
  localparam logic [CSR_AW-1:0] A_CMD_B    = 4'd7;
  localparam logic [CSR_AW-1:0] A_INT_HI   = 4'd8;
  localparam logic [CSR_AW-1:0] A_INT_LO   = 4'd9;
  localparam logic [CSR_AW-1:0] A_ERR_HI   = 4'd10;
  localparam logic [CSR_AW-1:0] A_ERR_LO   = 4'd11;
  localparam logic [CSR_AW-1:0] A_DONE_HI  = 4'd12;
  localparam logic [CSR_AW-1:0] A_DONE_LO  = 4'd13;
  localparam logic [CSR_AW-1:0] A_START_HI = 4'd14;
  localparam logic [CSR_AW-1:0] A_START_LO = 4'd15;

  // command slots: word A lanes 0..3 then word B lanes 0..3
  localparam int unsigned C_SET_REQ   = 0;
  localparam int unsigned C_CLR_REQ   = 1;
  localparam int unsigned C_SET_EIE   = 2;
  localparam int unsigned C_CLR_EIE   = 3;
  localparam int unsigned C_CLR_INT   = 4;
  localparam int unsigned C_CLR_ERR   = 5;
  localparam int unsigned C_SET_START = 6;
  localparam int unsigned C_CLR_DONE  = 7;

  // vector register kinds
  localparam int unsigned BV_PLAIN = 0;
  localparam int unsigned BV_W1C   = 1;
  localparam int unsigned BV_RO    = 2;

  typedef struct packed {
    logic             valid;
    logic             grp_pri;
    logic             ch_pri;
    logic [RCH_W-1:0] chan;
    logic [7:0]       flags;
  } synd_t;

  function automatic logic [WORD_W-1:0] synd_word(input synd_t s);
    return {s.valid, 15'd0, s.grp_pri, s.ch_pri, s.chan, s.flags};
  endfunction
endpackage

// File: rtl/dmacsr_cmd_dec.sv
module dmacsr_cmd_dec
  import dmacsr_pkg::*;
#(
  parameter int unsigned NCH = 64
) (
  input  logic                          hit_a,
  input  logic                          hit_b,
  input  logic [WORD_W-1:0]             wdata,
  input  logic [LANES-1:0]              be,
  output logic [NCMD-1:0][NCH-1:0]      cmd_vec
);
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0]     byte_v;
    logic           in_range;
    logic [NCH-1:0] vec_a;
    logic [NCH-1:0] vec_b;

    assign byte_v   = wdata[8*l +: 8];
    assign in_range = (32'(byte_v) < NCH);

    always_comb begin
      vec_a = '0;
      vec_b = '0;
      if (hit_a && be[l] && in_range) vec_a[byte_v[CHW-1:0]] = 1'b1;
      if (hit_b && be[l] && in_range) vec_b[byte_v[CHW-1:0]] = 1'b1;
    end

    assign cmd_vec[l]         = vec_a;
    assign cmd_vec[LANES + l] = vec_b;
  end
endmodule

// File: rtl/dmacsr_vec.sv
module dmacsr_vec
  import dmacsr_pkg::*;
#(
  parameter int unsigned NCH  = 64,
  parameter int unsigned KIND = BV_PLAIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] wmask,
  input  logic [NCH-1:0]    set_vec,
  input  logic [NCH-1:0]    clr_vec,
  output logic [NCH-1:0]    q
);
  logic [NCH-1:0] w_clr;
  logic           unused_sink;

  assign unused_sink = &{1'b0, wr_hi, wdata, wmask};

  for (genvar i = 0; i < NCH; i++) begin : g_bit
    localparam int unsigned J = i % WORD_W;
    logic hit_b;
    logic clr_b;
    logic nxt_b;
    logic en_b;
    logic q_b;

    if (i < WORD_W) begin : g_lo
      assign hit_b = wr_lo & wmask[J];
    end else begin : g_hi
      assign hit_b = wr_hi & wmask[J];
    end

    if (KIND == BV_W1C) begin : g_w1c
      assign clr_b = hit_b & wdata[J];
    end else begin : g_nw1c
      assign clr_b = 1'b0;
    end

    always_comb begin
      nxt_b = q_b;
      if ((KIND == BV_PLAIN) && hit_b) nxt_b = wdata[J];
      if (set_vec[i])                  nxt_b = 1'b1;
      if (clr_b || clr_vec[i])         nxt_b = 1'b0;
    end

    assign en_b = ((KIND != BV_RO) && hit_b) || set_vec[i] || clr_vec[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_b <= 1'b0;
      else if (en_b) q_b <= nxt_b;
    end

    assign q[i]     = q_b;
    assign w_clr[i] = clr_b;
  end

  // R7: any clear source wins over a set in the same cycle
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec | w_clr)) |=> ((q & $past(clr_vec | w_clr)) == '0));

  // R13: a set with no competing clear lands
  p_set_lands_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & ~clr_vec & ~w_clr)) |=>
      ((q & $past(set_vec & ~clr_vec & ~w_clr)) == $past(set_vec & ~clr_vec & ~w_clr)));
endmodule

// File: rtl/dmacsr_synd.sv
module dmacsr_synd
  import dmacsr_pkg::*;
#(
  parameter int unsigned NCH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rpt_valid,
  input  logic [RCH_W-1:0]  rpt_chan,
  input  logic [CODE_W-1:0] rpt_code,
  input  logic [NCH-1:0]    clr_err_vec,
  output synd_t             synd
);
  synd_t          synd_nxt;
  logic [NCH-1:0] chan_sel;
  logic           clr_hit;
  logic           synd_en;

  for (genvar j = 0; j < NCH; j++) begin : g_sel
    assign chan_sel[j] = (synd.chan == RCH_W'(j));
  end

  assign clr_hit = synd.valid && (|(chan_sel & clr_err_vec));

  always_comb begin
    synd_nxt = synd;
    synd_en  = 1'b0;
    if (synd.valid) begin
      if (clr_hit) begin
        synd_nxt.valid = 1'b0;
        synd_en        = 1'b1;
      end
    end else if (rpt_valid) begin
      synd_nxt.valid   = 1'b1;
      synd_nxt.grp_pri = rpt_code[9];
      synd_nxt.ch_pri  = rpt_code[8];
      synd_nxt.chan    = rpt_chan;
      synd_nxt.flags   = rpt_code[7:0];
      synd_en          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       synd <= '0;
    else if (synd_en) synd <= synd_nxt;
  end

  // R8: first report is kept while valid
  p_first_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (synd.valid && !clr_hit) |=> $stable(synd));

  // R8: an idle syndrome captures a report
  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!synd.valid && rpt_valid) |=> (synd.valid && synd.chan == $past(rpt_chan)));

  // R9: matching clear-error drops valid
  p_clear_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !synd.valid);
endmodule

// File: rtl/dmacsr_top.sv
module dmacsr_top
  import dmacsr_pkg::*;
#(
  parameter int unsigned NCH = 64
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_wr,
  input  logic [CSR_AW-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [LANES-1:0]  bus_be,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    eng_int_set,
  input  logic [NCH-1:0]    eng_err_set,
  input  logic [NCH-1:0]    eng_done_set,
  input  logic [NCH-1:0]    eng_start_ack,
  input  logic              eng_rpt_valid,
  input  logic [RCH_W-1:0]  eng_rpt_chan,
  input  logic [CODE_W-1:0] eng_rpt_code,
  output logic [NCH-1:0]    chan_req_en,
  output logic [NCH-1:0]    chan_start,
  output logic              arb_rr_group,
  output logic              arb_rr_chan,
  output logic              irq
);
  localparam bit HAS_HI = (NCH > WORD_W);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  // write decode
  logic [WORD_W-1:0] wmask;
  logic              hit_ctrl, hit_cmd_a, hit_cmd_b;
  logic              hit_req_lo, hit_req_hi, hit_eie_lo, hit_eie_hi;
  logic              hit_int_lo, hit_int_hi, hit_err_lo, hit_err_hi;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign wmask[8*l +: 8] = {8{bus_be[l]}};
  end

  assign hit_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign hit_cmd_a  = bus_wr && (bus_addr == A_CMD_A);
  assign hit_cmd_b  = bus_wr && (bus_addr == A_CMD_B);
  assign hit_req_lo = bus_wr && (bus_addr == A_REQ_LO);
  assign hit_req_hi = bus_wr && (bus_addr == A_REQ_HI) && HAS_HI;
  assign hit_eie_lo = bus_wr && (bus_addr == A_EIE_LO);
  assign hit_eie_hi = bus_wr && (bus_addr == A_EIE_HI) && HAS_HI;
  assign hit_int_lo = bus_wr && (bus_addr == A_INT_LO);
  assign hit_int_hi = bus_wr && (bus_addr == A_INT_HI) && HAS_HI;
  assign hit_err_lo = bus_wr && (bus_addr == A_ERR_LO);
  assign hit_err_hi = bus_wr && (bus_addr == A_ERR_HI) && HAS_HI;

  // command bytes
  logic [NCMD-1:0][NCH-1:0] cmd_vec;

  dmacsr_cmd_dec #(.NCH(NCH)) u_cmd (
    .hit_a   (hit_cmd_a),
    .hit_b   (hit_cmd_b),
    .wdata   (bus_wdata),
    .be      (bus_be),
    .cmd_vec (cmd_vec)
  );

  // per-channel vectors
  logic [NCH-1:0] req_q, eie_q, int_q, err_q, done_q, start_q;

  dmacsr_vec #(.NCH(NCH), .KIND(BV_PLAIN)) u_req (
    .clk(clk), .rst_n(rst_n), .wr_lo(hit_req_lo), .wr_hi(hit_req_hi),
    .wdata(bus_wdata), .wmask(wmask),
    .set_vec(cmd_vec[C_SET_REQ]), .clr_vec(cmd_vec[C_CLR_REQ]), .q(req_q));

  dmacsr_vec #(.NCH(NCH), .KIND(BV_PLAIN)) u_eie (
    .clk(clk), .rst_n(rst_n), .wr_lo(hit_eie_lo), .wr_hi(hit_eie_hi),
    .wdata(bus_wdata), .wmask(wmask),
    .set_vec(cmd_vec[C_SET_EIE]), .clr_vec(cmd_vec[C_CLR_EIE]), .q(eie_q));

  dmacsr_vec #(.NCH(NCH), .KIND(BV_W1C)) u_int (
    .clk(clk), .rst_n(rst_n), .wr_lo(hit_int_lo), .wr_hi(hit_int_hi),
    .wdata(bus_wdata), .wmask(wmask),
    .set_vec(eng_int_set), .clr_vec(cmd_vec[C_CLR_INT]), .q(int_q));

  dmacsr_vec #(.NCH(NCH), .KIND(BV_W1C)) u_err (
    .clk(clk), .rst_n(rst_n), .wr_lo(hit_err_lo), .wr_hi(hit_err_hi),
    .wdata(bus_wdata), .wmask(wmask),
    .set_vec(eng_err_set), .clr_vec(cmd_vec[C_CLR_ERR]), .q(err_q));

  dmacsr_vec #(.NCH(NCH), .KIND(BV_RO)) u_done (
    .clk(clk), .rst_n(rst_n), .wr_lo(1'b0), .wr_hi(1'b0),
    .wdata(bus_wdata), .wmask(wmask),
    .set_vec(eng_done_set), .clr_vec(cmd_vec[C_CLR_DONE]), .q(done_q));

  dmacsr_vec #(.NCH(NCH), .KIND(BV_RO)) u_start (
    .clk(clk), .rst_n(rst_n), .wr_lo(1'b0), .wr_hi(1'b0),
    .wdata(bus_wdata), .wmask(wmask),
    .set_vec(cmd_vec[C_SET_START]), .clr_vec(eng_start_ack), .q(start_q));

  // error syndrome
  synd_t synd;

  dmacsr_synd #(.NCH(NCH)) u_synd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rpt_valid   (eng_rpt_valid),
    .rpt_chan    (eng_rpt_chan),
    .rpt_code    (eng_rpt_code),
    .clr_err_vec (cmd_vec[C_CLR_ERR]),
    .synd        (synd)
  );

  // arbitration control
  logic [1:0] arb_q, arb_nxt;
  logic       arb_en;

  assign arb_en  = hit_ctrl && bus_be[0];
  assign arb_nxt = bus_wdata[3:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arb_q <= 2'b00;
    else if (arb_en) arb_q <= arb_nxt;
  end

  // read mux
  logic [2*WORD_W-1:0] req_w, eie_w, int_w, err_w, done_w, start_w;

  assign req_w   = (2*WORD_W)'(req_q);
  assign eie_w   = (2*WORD_W)'(eie_q);
  assign int_w   = (2*WORD_W)'(int_q);
  assign err_w   = (2*WORD_W)'(err_q);
  assign done_w  = (2*WORD_W)'(done_q);
  assign start_w = (2*WORD_W)'(start_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:     bus_rdata = {28'd0, arb_q, 2'b00};
      A_SYND:     bus_rdata = synd_word(synd);
      A_REQ_HI:   bus_rdata = req_w[2*WORD_W-1:WORD_W];
      A_REQ_LO:   bus_rdata = req_w[WORD_W-1:0];
      A_EIE_HI:   bus_rdata = eie_w[2*WORD_W-1:WORD_W];
      A_EIE_LO:   bus_rdata = eie_w[WORD_W-1:0];
      A_INT_HI:   bus_rdata = int_w[2*WORD_W-1:WORD_W];
      A_INT_LO:   bus_rdata = int_w[WORD_W-1:0];
      A_ERR_HI:   bus_rdata = err_w[2*WORD_W-1:WORD_W];
      A_ERR_LO:   bus_rdata = err_w[WORD_W-1:0];
      A_DONE_HI:  bus_rdata = done_w[2*WORD_W-1:WORD_W];
      A_DONE_LO:  bus_rdata = done_w[WORD_W-1:0];
      A_START_HI: bus_rdata = start_w[2*WORD_W-1:WORD_W];
      A_START_LO: bus_rdata = start_w[WORD_W-1:0];
      default:    bus_rdata = '0;
    endcase
  end

  assign chan_req_en  = req_q;
  assign chan_start   = start_q;
  assign arb_rr_group = arb_q[1];
  assign arb_rr_chan  = arb_q[0];
  assign irq          = (|int_q) || (|(err_q & eie_q));

  // R5: an out-of-range set-request byte alone leaves the enables alone
  p_cmd_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmd_a && bus_be == 4'b0001 && 32'(bus_wdata[7:0]) >= NCH) |=> $stable(req_q));

  // R11: arbitration outputs follow a control write
  p_ctrl_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctrl && bus_be[0]) |=>
      (arb_rr_group == $past(bus_wdata[3]) && arb_rr_chan == $past(bus_wdata[2])));
endmodule

// File: tb/tb_dmacsr_top.sv
`timescale 1ns/1ps
module tb_dmacsr_top;
  import dmacsr_pkg::*;

  localparam int unsigned N = 64;
  localparam int unsigned M = 16;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] rdata, rdata16;
  logic [N-1:0] eng_int_set, eng_err_set, eng_done_set, eng_start_ack;
  logic        eng_rpt_valid;
  logic [5:0]  eng_rpt_chan;
  logic [9:0]  eng_rpt_code;
  logic [N-1:0] chan_req_en, chan_start;
  logic        arb_rr_group, arb_rr_chan, irq;
  logic [M-1:0] req16, start16;
  logic        g16, c16, irq16;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dmacsr_top #(.NCH(N)) dut (
    .clk(clk), .rst_ni(rst_ni), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(rdata),
    .eng_int_set(eng_int_set), .eng_err_set(eng_err_set),
    .eng_done_set(eng_done_set), .eng_start_ack(eng_start_ack),
    .eng_rpt_valid(eng_rpt_valid), .eng_rpt_chan(eng_rpt_chan),
    .eng_rpt_code(eng_rpt_code), .chan_req_en(chan_req_en),
    .chan_start(chan_start), .arb_rr_group(arb_rr_group),
    .arb_rr_chan(arb_rr_chan), .irq(irq));

  dmacsr_top #(.NCH(M)) dut16 (
    .clk(clk), .rst_ni(rst_ni), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(rdata16),
    .eng_int_set(eng_int_set[M-1:0]), .eng_err_set(eng_err_set[M-1:0]),
    .eng_done_set(eng_done_set[M-1:0]), .eng_start_ack(eng_start_ack[M-1:0]),
    .eng_rpt_valid(eng_rpt_valid), .eng_rpt_chan(eng_rpt_chan),
    .eng_rpt_code(eng_rpt_code), .chan_req_en(req16),
    .chan_start(start16), .arb_rr_group(g16),
    .arb_rr_chan(c16), .irq(irq16));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(req, 64'(rdata), 64'(exp));
  endtask

  task automatic rd16(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(req, 64'(rdata16), 64'(exp));
  endtask

  task automatic eng(input logic [N-1:0] i, input logic [N-1:0] e,
                     input logic [N-1:0] d, input logic [N-1:0] k);
    eng_int_set = i; eng_err_set = e; eng_done_set = d; eng_start_ack = k;
    @(negedge clk);
    eng_int_set = '0; eng_err_set = '0; eng_done_set = '0; eng_start_ack = '0;
  endtask

  task automatic rpt(input logic [5:0] ch, input logic [9:0] code);
    eng_rpt_valid = 1'b1; eng_rpt_chan = ch; eng_rpt_code = code;
    @(negedge clk);
    eng_rpt_valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a++) rd("R1 reset word", 4'(a), 32'h0);
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 req_en", chan_req_en, 64'd0);
    chk("R1 start", chan_start, 64'd0);
    chk("R1 arb", 64'({arb_rr_group, arb_rr_chan}), 64'd0);
  endtask

  task automatic t_word_split;
    wr(A_REQ_LO, 32'h8000_0001, 4'hF);
    wr(A_REQ_HI, 32'h0000_0004, 4'hF);
    #1 chk("R2 req_en split", chan_req_en, 64'h0000_0004_8000_0001);
    rd("R2 req hi", A_REQ_HI, 32'h4);
    wr(A_REQ_LO, 32'hFFFF_FFFF, 4'b0001);
    rd("R2 byte enable", A_REQ_LO, 32'h8000_00FF);
    wr(A_EIE_HI, 32'h0001_0000, 4'hF);
    rd("R2 eie hi", A_EIE_HI, 32'h0001_0000);
    wr(A_EIE_HI, 32'h0, 4'hF);
    wr(A_REQ_LO, 32'h0, 4'hF);
    wr(A_REQ_HI, 32'h0, 4'hF);
    rd("R2 req lo cleared", A_REQ_LO, 32'h0);
  endtask

  task automatic t_cmd_a;
    wr(A_CMD_A, 32'd37, 4'b0001);
    rd("R3 set req 37", A_REQ_HI, 32'h20);
    wr(A_CMD_A, 32'd2 << 16, 4'b0100);
    rd("R3 set eie 2", A_EIE_LO, 32'h4);
    wr(A_CMD_A, 32'd37 << 8, 4'b0010);
    rd("R3 clr req 37", A_REQ_HI, 32'h0);
    wr(A_CMD_A, 32'd2 << 24, 4'b1000);
    rd("R3 clr eie 2", A_EIE_LO, 32'h0);
    wr(A_CMD_A, 32'h003F_003F, 4'b0101);
    rd("R3 two lanes req", A_REQ_HI, 32'h8000_0000);
    rd("R3 two lanes eie", A_EIE_HI, 32'h8000_0000);
  endtask

  task automatic t_cmd_b;
    eng((64'd1 << 40) | 64'd2, 64'd1 << 7, (64'd1 << 50) | (64'd1 << 9), '0);
    rd("R6 int lo set", A_INT_LO, 32'h2);
    rd("R6 int hi set", A_INT_HI, 32'h100);
    rd("R6 err lo set", A_ERR_LO, 32'h80);
    rd("R13 done lo", A_DONE_LO, 32'h200);
    rd("R13 done hi", A_DONE_HI, 32'h0004_0000);
    wr(A_CMD_B, 32'd40, 4'b0001);
    rd("R4 clr int 40", A_INT_HI, 32'h0);
    wr(A_CMD_B, 32'd7 << 8, 4'b0010);
    rd("R4 clr err 7", A_ERR_LO, 32'h0);
    wr(A_CMD_B, 32'd50 << 24, 4'b1000);
    rd("R4 clr done 50", A_DONE_HI, 32'h0);
    wr(A_CMD_B, 32'd9 << 24, 4'b1000);
    rd("R4 clr done 9", A_DONE_LO, 32'h0);
    wr(A_DONE_LO, 32'hFFFF_FFFF, 4'hF);
    rd("R13 done read-only", A_DONE_LO, 32'h0);
    wr(A_CMD_B, 32'd12 << 16, 4'b0100);
    #1 chk("R4 set start 12", chan_start, 64'd1 << 12);
    rd("R13 start lo", A_START_LO, 32'h1000);
    eng('0, '0, '0, 64'd1 << 12);
    rd("R13 start ack", A_START_LO, 32'h0);
    chk("R4 irq from int 1", 64'(irq), 64'd1);
  endtask

  task automatic t_range;
    wr(A_CMD_A, 32'd64, 4'b0001);
    rd("R5 byte 64 hi", A_REQ_HI, 32'h8000_0000);
    rd("R5 byte 64 lo", A_REQ_LO, 32'h0);
    wr(A_CMD_A, 32'hC5, 4'b0001);
    rd("R5 byte C5 hi", A_REQ_HI, 32'h8000_0000);
    wr(A_CMD_A, 32'd20, 4'b0001);
    rd16("R5 byte 20 on 16ch", A_REQ_LO, 32'h0);
    rd("R5 byte 20 on 64ch", A_REQ_LO, 32'h0010_0000);
    wr(A_CMD_A, 32'd20 << 8, 4'b0010);
    wr(A_CMD_A, 32'd15, 4'b0001);
    rd16("R5 byte 15 on 16ch", A_REQ_LO, 32'h8000);
    rd("R5 byte 15 on 64ch", A_REQ_LO, 32'h8000);
  endtask

  task automatic t_w1c;
    eng((64'd1 << 33) | 64'h7, '0, '0, '0);
    rd("R6 int lo", A_INT_LO, 32'h7);
    rd("R6 int hi", A_INT_HI, 32'h2);
    wr(A_INT_LO, 32'h5, 4'hF);
    rd("R6 w1c mask", A_INT_LO, 32'h2);
    wr(A_INT_HI, 32'h0, 4'hF);
    rd("R6 zero no effect", A_INT_HI, 32'h2);
    wr(A_INT_LO, 32'hFFFF_FFFF, 4'hF);
    wr(A_INT_HI, 32'hFFFF_FFFF, 4'hF);
    rd("R6 all ones lo", A_INT_LO, 32'h0);
    rd("R6 all ones hi", A_INT_HI, 32'h0);
    eng('0, 64'hF0, '0, '0);
    rd("R6 err lo", A_ERR_LO, 32'hF0);
    wr(A_ERR_LO, 32'hFFFF_FFFF, 4'hF);
    rd("R6 err cleared", A_ERR_LO, 32'h0);
  endtask

  task automatic t_clear_wins;
    bus_addr = A_CMD_B; bus_wdata = 32'd3; bus_be = 4'b0001; bus_wr = 1'b1;
    eng_int_set = 64'd1 << 3;
    @(negedge clk);
    bus_wr = 1'b0; eng_int_set = '0;
    rd("R7 int set vs clr cmd", A_INT_LO, 32'h0);
    bus_addr = A_ERR_LO; bus_wdata = 32'h10; bus_be = 4'hF; bus_wr = 1'b1;
    eng_err_set = 64'd1 << 4;
    @(negedge clk);
    bus_wr = 1'b0; eng_err_set = '0;
    rd("R7 err set vs w1c", A_ERR_LO, 32'h0);
    wr(A_CMD_A, 32'h0606, 4'b0011);
    rd("R7 set and clr lanes", A_REQ_LO, 32'h8000);
    bus_addr = A_CMD_B; bus_wdata = 32'd5 << 16; bus_be = 4'b0100; bus_wr = 1'b1;
    eng_start_ack = 64'd1 << 5;
    @(negedge clk);
    bus_wr = 1'b0; eng_start_ack = '0;
    rd("R7 start vs ack", A_START_LO, 32'h0);
  endtask

  task automatic t_synd;
    rpt(6'd21, 10'h2A5);
    rd("R8 capture", A_SYND, 32'h8000_95A5);
    rpt(6'd3, 10'h3FF);
    rd("R8 first kept", A_SYND, 32'h8000_95A5);
    wr(A_CMD_B, 32'd3 << 8, 4'b0010);
    rd("R9 other chan clear", A_SYND, 32'h8000_95A5);
    wr(A_CMD_B, 32'd21 << 8, 4'b0010);
    rd("R9 matching clear", A_SYND, 32'h0000_95A5);
    rpt(6'd60, 10'h143);
    rd("R8 recapture", A_SYND, 32'h8000_7C43);
  endtask

  task automatic t_irq;
    #1 chk("R10 idle", 64'(irq), 64'd0);
    eng('0, 64'd1 << 35, '0, '0);
    #1 chk("R10 err masked", 64'(irq), 64'd0);
    wr(A_CMD_A, 32'd35 << 16, 4'b0100);
    #1 chk("R10 err enabled", 64'(irq), 64'd1);
    wr(A_CMD_A, 32'd35 << 24, 4'b1000);
    #1 chk("R10 enable removed", 64'(irq), 64'd0);
    eng('0, 64'd1 << 63, '0, '0);
    #1 chk("R10 err 63 enabled", 64'(irq), 64'd1);
    wr(A_ERR_HI, 32'hFFFF_FFFF, 4'hF);
    #1 chk("R10 errors cleared", 64'(irq), 64'd0);
    eng(64'd1 << 60, '0, '0, '0);
    #1 chk("R10 int pending", 64'(irq), 64'd1);
    wr(A_CMD_B, 32'd60, 4'b0001);
    #1 chk("R10 int cleared", 64'(irq), 64'd0);
  endtask

  task automatic t_ctrl;
    wr(A_CTRL, 32'hFFFF_FFFF, 4'hF);
    rd("R11 ctrl readback", A_CTRL, 32'hC);
    chk("R11 both rr", 64'({arb_rr_group, arb_rr_chan}), 64'd3);
    wr(A_CTRL, 32'h4, 4'hF);
    chk("R11 chan rr only", 64'({arb_rr_group, arb_rr_chan}), 64'd1);
    wr(A_CTRL, 32'h0, 4'b1110);
    rd("R11 lane 0 off", A_CTRL, 32'h4);
  endtask

  task automatic t_reduced;
    wr(A_REQ_HI, 32'hFFFF_FFFF, 4'hF);
    rd16("R12 req hi empty", A_REQ_HI, 32'h0);
    rd("R12 64ch req hi", A_REQ_HI, 32'hFFFF_FFFF);
    wr(A_REQ_LO, 32'hFFFF_FFFF, 4'hF);
    rd16("R12 req lo width", A_REQ_LO, 32'h0000_FFFF);
    eng(64'd1 << 40, '0, '0, '0);
    rd16("R12 int hi empty", A_INT_HI, 32'h0);
    rd("R12 64ch int hi", A_INT_HI, 32'h100);
  endtask

  initial begin
    rst_ni = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
    eng_int_set = '0; eng_err_set = '0; eng_done_set = '0; eng_start_ack = '0;
    eng_rpt_valid = 1'b0; eng_rpt_chan = '0; eng_rpt_code = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_word_split();
    t_cmd_a();
    t_cmd_b();
    wr(A_INT_LO, 32'hFFFF_FFFF, 4'hF);
    t_range();
    t_w1c();
    t_clear_wins();
    t_synd();
    t_irq();
    t_ctrl();
    t_reduced();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule